// File: doc/BRIEF.md
# I2C Slave Transmitter with Status Codes

This block is the read side of an I2C target. It watches an open-drain SCL/SDA pair, oversampled by the system clock. When a master addresses it with its own 7-bit address and the read direction bit, it acknowledges. It then hands the master one byte after another from a host-written data register.

Each step of a transfer is reported through an 8-bit status code and an interrupt flag. While the flag is pending, the block holds SCL low, so the host can take as long as it needs to read the status and supply the next byte. When the host clears the flag, the stretch is released and the next byte is loaded.

The host can end a transfer gracefully by clearing its acknowledge-enable bit. The byte in flight becomes the last one. After that byte the block detaches from the bus, so a master that keeps clocking reads only ones.

A separate input marks that a master-side arbitration loss has just happened. The next address match then reports a dedicated code, which lets the host tell the two entry paths apart.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, irq is 0, status reads F8h, and neither sda_oe nor scl_oe is asserted.
- R2: Address byte `{own_addr, 1}` received MSB first while ack_en is 1: the block pulls SDA low during the 9th clock, and after that clock's falling edge it sets irq with status A8h.
- R3: Address byte with a different address, or with direction bit 0: SDA is not pulled low in the 9th clock and irq stays 0.
- R4: While ack_en is 0 the own address is not acknowledged. Setting ack_en back to 1 restores recognition at the next address byte.
- R5: A one-cycle pulse on arb_lost before a matching read address makes that address report status B0h instead of A8h.
- R6: While irq is 1, scl_oe holds SCL low even if the master releases it. One cycle after the host pulses irq_clr, irq is 0 and scl_oe is released.
- R7: On the irq_clr pulse after A8h, B0h or B8h, tx_data is loaded and shifted out MSB first. sda_oe changes only while SCL is low.
- R8: After a byte that the master acknowledges (SDA 0 in the 9th clock), irq sets with B8h. After a byte that it does not acknowledge (SDA 1), irq sets with C0h. After C0h is cleared the block no longer drives SDA.
- R9: If ack_en is 0 when a byte is loaded, that byte is the last one. When the master acknowledges it, irq sets with C8h. After clearing, further master clocks read FFh and irq stays 0.
- R10: Whenever irq is 0, status reads F8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | 7 | Own 7-bit target address |
| ack_en | input | 1 | Acknowledge enable |
| tx_data | input | 8 | Next byte to transmit |
| irq_clr | input | 1 | Host pulse clearing the interrupt flag |
| arb_lost | input | 1 | Pulse: master arbitration was just lost |
| irq | output | 1 | Interrupt flag |
| status | output | 8 | Status code |

## Verification
The bench acts as a bit-level master on the wired-AND bus.

It goes after the places where a wrong status or a missing detach would stay silent:
- the final-byte path, where a design that samples ack_en late or not at all would report B8h instead of C8h and keep driving zeros after it;
- a master NACK, which must report C0h and not B8h;
- the arbitration-loss entry, which must report B0h once and then fall back to A8h;
- a read address while ack_en is 0, or a write address, which must draw no acknowledge;
- the stretch itself, where a block that releases SCL early would let the master clock a byte the host never loaded.

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [AW-1:0] own_addr,
  input  logic          ack_en,
  input  logic [DW-1:0] tx_data,
  input  logic          irq_clr,
  input  logic          arb_lost,
  output logic          irq,
  output logic [7:0]    status
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [CW-1:0] ADR_BITS = CW'(AW + 1);

  localparam logic [7:0] ST_NONE   = 8'hF8;
  localparam logic [7:0] ST_ADDR   = 8'hA8;
  localparam logic [7:0] ST_ARB    = 8'hB0;
  localparam logic [7:0] ST_ACKED  = 8'hB8;
  localparam logic [7:0] ST_NACKED = 8'hC0;
  localparam logic [7:0] ST_FINAL  = 8'hC8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_HOLD, S_TX, S_MACK} st_t;

  st_t            st;
  logic [2:0]     scl_p, sda_p;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  sr;
  logic [7:0]     code;
  logic           last, mnack, arb_f;

  wire scl_s = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_d = sda_p[2];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire go_tx     = (code == ST_ADDR) | (code == ST_ARB) | (code == ST_ACKED);
  wire addr_hit  = (sr[AW:1] == own_addr) & sr[0] & ack_en;

  assign scl_oe = (st == S_HOLD);
  assign sda_oe = (st == S_AACK) | ((st == S_TX) & ~sr[DW-1]);
  assign status = irq ? code : ST_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sr    <= '0;
      code  <= ST_NONE;
      irq   <= 1'b0;
      last  <= 1'b0;
      mnack <= 1'b0;
      arb_f <= 1'b0;
    end else begin
      if (arb_lost) arb_f <= 1'b1;
      if (st == S_HOLD) begin
        if (irq_clr) begin
          irq <= 1'b0;
          if (go_tx) begin
            sr   <= tx_data;
            cnt  <= '0;
            last <= ~ack_en;
            st   <= S_TX;
          end else begin
            st <= S_IDLE;
          end
        end
      end else if (stop_det) begin
        st <= S_IDLE;
        if (!arb_lost) arb_f <= 1'b0;
      end else if (start_det) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              sr  <= {sr[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == ADR_BITS) begin
              st <= addr_hit ? S_AACK : S_IDLE;
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              irq   <= 1'b1;
              code  <= arb_f ? ST_ARB : ST_ADDR;
              arb_f <= 1'b0;
              st    <= S_HOLD;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              sr  <= {sr[DW-2:0], 1'b1};
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) st <= S_MACK;
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mnack <= sda_s;
            end else if (scl_fall) begin
              irq  <= 1'b1;
              code <= mnack ? ST_NACKED : (last ? ST_FINAL : ST_ACKED);
              st   <= S_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !irq && !sda_oe && !scl_oe);
  a_r6_stretch_while_pending: assert property (@(posedge clk) disable iff (!rst_n) irq |-> scl_oe);
  a_r6_release_on_clear: assert property (@(posedge clk) disable iff (!rst_n) (irq && irq_clr) |=> (!irq && !scl_oe));
  a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_s);
  a_r9_detach_after_final: assert property (@(posedge clk) disable iff (!rst_n) (irq && irq_clr && status == ST_FINAL) |=> !sda_oe);
  a_r10_idle_code: assert property (@(posedge clk) disable iff (!rst_n) !irq |-> status == ST_NONE);
  a_r2_valid_codes: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status == ST_ADDR || status == ST_ARB || status == ST_ACKED || status == ST_NACKED || status == ST_FINAL));
endmodule

// File: tb/tb_i2c_slave_tx.sv
module tb_i2c_slave_tx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] ME = 7'h52;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic ack_en = 1, irq_clr = 0, arb_lost = 0;
  logic [7:0] tx_data = 8'h00;
  logic scl_oe, sda_oe, irq;
  logic [7:0] status;
  wire scl_ln = scl_m & ~scl_oe;
  wire sda_ln = sda_m & ~sda_oe;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slave_tx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(ME), .ack_en(ack_en),
    .tx_data(tx_data), .irq_clr(irq_clr), .arb_lost(arb_lost),
    .irq(irq), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1;
    w(1);
    while (!scl_ln) w(1);
    w(Q);
  endtask

  task automatic start_c();
    sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q);
  endtask

  task automatic stop_c();
    sda_m = 0; w(Q); scl_up(); sda_m = 1; w(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; w(Q); scl_up(); scl_m = 0; w(Q);
  endtask

  task automatic rbit(output logic b, input string req);
    logic first;
    sda_m = 1; w(Q);
    scl_m = 1; w(1);
    while (!scl_ln) w(1);
    first = sda_ln;
    w(Q);
    b = sda_ln;
    chk(req, b, first);
    scl_m = 0; w(Q);
  endtask

  task automatic addr(input logic [6:0] a, input logic rw, output logic ack);
    start_c();
    for (int i = 6; i >= 0; i--) wbit(a[i]);
    wbit(rw);
    rbit(ack, "R7 stable");
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i], "R7 sda stable while scl high");
    wbit(mack);
  endtask

  task automatic clr();
    irq_clr = 1; w(1); irq_clr = 0; w(1);
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 status", status, 8'hF8);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
  endtask

  task automatic t_ignore();
    logic a;
    addr(7'h13, 1, a);
    chk("R3 other address nack", a, 1);
    chk("R3 no irq", irq, 0);
    stop_c();
    addr(ME, 0, a);
    chk("R3 write bit nack", a, 1);
    chk("R3 no irq write", irq, 0);
    chk("R10 status idle", status, 8'hF8);
    stop_c();
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    addr(ME, 1, a);
    chk("R2 ack", a, 0);
    chk("R2 irq", irq, 1);
    chk("R2 status A8", status, 8'hA8);
    scl_m = 1; w(12);
    chk("R6 scl held low", scl_ln, 0);
    scl_m = 0; w(2);
    tx_data = 8'hA5; clr();
    chk("R6 irq cleared", irq, 0);
    chk("R6 scl released", scl_oe, 0);
    chk("R10 status F8 after clear", status, 8'hF8);
    rbyte(0, d);
    chk("R7 first byte", d, 8'hA5);
    chk("R8 status B8", status, 8'hB8);
    tx_data = 8'h3C; clr();
    rbyte(1, d);
    chk("R7 second byte", d, 8'h3C);
    chk("R8 status C0", status, 8'hC0);
    clr();
    chk("R8 sda released", sda_oe, 0);
    chk("R10 status after C0", status, 8'hF8);
    stop_c();
  endtask

  task automatic t_final();
    logic a;
    logic [7:0] d;
    addr(ME, 1, a);
    chk("R2 ack", a, 0);
    ack_en = 0; tx_data = 8'h5A; clr();
    rbyte(0, d);
    chk("R9 last byte", d, 8'h5A);
    chk("R9 status C8", status, 8'hC8);
    clr();
    rbyte(0, d);
    chk("R9 detached reads ones", d, 8'hFF);
    chk("R9 no irq after detach", irq, 0);
    stop_c();
    addr(ME, 1, a);
    chk("R4 no ack while disabled", a, 1);
    chk("R4 no irq", irq, 0);
    stop_c();
    ack_en = 1;
    addr(ME, 1, a);
    chk("R4 ack resumes", a, 0);
    chk("R4 status A8", status, 8'hA8);
    tx_data = 8'h81; clr();
    rbyte(1, d);
    chk("R7 byte 81", d, 8'h81);
    chk("R8 C0", status, 8'hC0);
    clr(); stop_c();
  endtask

  task automatic t_arb();
    logic a;
    logic [7:0] d;
    arb_lost = 1; w(1); arb_lost = 0;
    addr(ME, 1, a);
    chk("R5 ack", a, 0);
    chk("R5 status B0", status, 8'hB0);
    tx_data = 8'h0F; clr();
    rbyte(1, d);
    chk("R5 byte after B0", d, 8'h0F);
    clr(); stop_c();
    addr(ME, 1, a);
    chk("R5 back to A8", status, 8'hA8);
    tx_data = 8'hFF; clr();
    rbyte(1, d);
    clr(); stop_c();
  endtask

  initial begin
    w(3); rst_n = 1; w(3);
    t_reset();
    t_ignore();
    t_read();
    t_final();
    t_arb();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule